// File: doc/BRIEF.md
# Flash Byte Programming and Erase Sequencer

This block drives a byte-wide flash device through a simple synchronous bus master port. On a start pulse it either erases the whole chip or programs a run of consecutive addresses. The bytes to program come one at a time from a ready/valid stream. Before it issues any command it waits until the programming supply is reported ready.

To program a byte, the block writes the setup command 10h and then writes the data byte to the target address. It then reads that address again and again. The byte has passed once bit 7 of the read value equals bit 7 of the data written. If bit 7 differs and bit 5 reads 1, the block reads once more before it decides. A second mismatch is a failure. To erase, the block writes 30h twice and polls until bit 7 reads 1, with the same second-read rule.

A failure, or an abort request, sends FFh to the device twice. This returns the device to read mode even when it was left waiting for program data. The block then raises `fail` and reports the address it was working on. A run that completes raises `done`. The `done` and `fail` flags hold until the next accepted start.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and right after it, `bus_req`, `in_ready`, `done` and `fail` are all 0.
- R2: After an accepted start, no setup, data or poll access is issued until `hv_ready` has been sampled high.
- R3: Each programmed byte produces exactly two bus writes, in this order: 10h, then the stream byte written to the target address. A stream byte is taken only when its data write is acknowledged. `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until `bus_ack`.
- R4: A poll read is a read of the target address. The byte passes when read bit 7 equals bit 7 of the written byte. The address then advances by one. After `byte_count` bytes have passed, `done` rises and no further access is made.
- R5: A poll read with bit 7 mismatched and bit 5 = 0 is followed by another poll read.
- R6: A poll read with bit 7 mismatched and bit 5 = 1 is followed by exactly one more read. If bit 7 matches on that read, the byte passes.
- R7: If bit 7 still mismatches on that extra read, the block writes FFh twice, then raises `fail` with `fail_addr` set to the failing address. `done` stays 0.
- R8: In erase mode (`erase_mode` = 1 at start) the block writes 30h twice, then polls until bit 7 reads 1, using the rules of R5 and R6. An erase failure reports `start_addr` in `fail_addr`.
- R9: An `abort` pulse while busy leads to two FFh writes, then `fail` = 1 with `fail_addr` set to the current address.
- R10: `done` and `fail` hold until the next start. A start while busy is ignored. The two flags are never high together.
- R11: A program start with `byte_count` = 0 sets `done` on the next cycle without any bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_ready | input | 1 | Programming supply is up |
| start | input | 1 | Start pulse, taken only when idle |
| erase_mode | input | 1 | 1 selects chip erase, 0 selects programming |
| abort | input | 1 | Abort request while busy |
| start_addr | input | AW | First target address |
| byte_count | input | AW | Number of bytes to program |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte consumed |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| done | output | 1 | Run completed |
| fail | output | 1 | Run failed or aborted |
| fail_addr | output | AW | Address at failure or abort |

## Verification
The device model answers polls in four ways:
- A plain byte returns two mismatching reads with bit 5 at 0. This separates continued polling from an early pass.
- A byte at the late address shows bit 5 with a mismatch and then completes. This separates the second-read rule from an immediate failure.
- A byte at the failing address keeps mismatching. This exercises the reset writes and the failing address.
- A byte of FFh completes on its first read.

The program patterns mix bytes whose bit 7 is 0 and bytes whose bit 7 is 1, so a wrong polarity in the comparison shows up. Erase runs cover both normal completion and a stuck status. Separate runs cover an abort while the supply is not ready, a zero byte count, and a start pulse given while busy.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW = 18,
  parameter logic [7:0] CMD_PROG  = 8'h10,
  parameter logic [7:0] CMD_ERASE = 8'h30,
  parameter logic [7:0] CMD_RESET = 8'hFF,
  parameter int BIT_DONE = 7,
  parameter int BIT_LIMIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_ready,
  input  logic          start,
  input  logic          erase_mode,
  input  logic          abort,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] byte_count,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  typedef enum logic [3:0] {
    S_IDLE, S_HV, S_SETUP, S_DATA, S_ERASE2, S_POLL, S_RECHK, S_RST1, S_RST2
  } st_t;

  st_t           st;
  logic [AW-1:0] addr, left;
  logic          exp7, erase_q, abort_q, done_q, fail_q;
  logic [AW-1:0] fail_addr_q;
  logic          ok7, lim, last, unused_rd;

  assign ok7  = bus_rdata[BIT_DONE] == exp7;
  assign lim  = bus_rdata[BIT_LIMIT];
  assign last = erase_q || (left == AW'(1));
  assign unused_rd = ^bus_rdata;

  assign bus_req = (st == S_SETUP) || (st == S_ERASE2) || (st == S_POLL) ||
                   (st == S_RECHK) || (st == S_RST1) || (st == S_RST2) ||
                   ((st == S_DATA) && in_valid);
  assign bus_we  = (st != S_POLL) && (st != S_RECHK);
  assign bus_addr = addr;
  assign in_ready = (st == S_DATA) && bus_ack;
  assign done = done_q;
  assign fail = fail_q;
  assign fail_addr = fail_addr_q;

  always_comb begin
    case (st)
      S_SETUP:          bus_wdata = erase_q ? CMD_ERASE : CMD_PROG;
      S_DATA:           bus_wdata = in_data;
      S_ERASE2:         bus_wdata = CMD_ERASE;
      S_RST1, S_RST2:   bus_wdata = CMD_RESET;
      default:          bus_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      addr        <= '0;
      left        <= '0;
      exp7        <= 1'b0;
      erase_q     <= 1'b0;
      abort_q     <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      if (st == S_IDLE) abort_q <= 1'b0;
      else if (abort)   abort_q <= 1'b1;

      case (st)
        S_IDLE: if (start) begin
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          addr    <= start_addr;
          left    <= byte_count;
          erase_q <= erase_mode;
          exp7    <= erase_mode;
          if (!erase_mode && byte_count == '0) done_q <= 1'b1;
          else st <= S_HV;
        end
        S_HV: begin
          if (abort_q)       st <= S_RST1;
          else if (hv_ready) st <= S_SETUP;
        end
        S_SETUP: if (bus_ack) begin
          if (abort_q)      st <= S_RST1;
          else if (erase_q) st <= S_ERASE2;
          else              st <= S_DATA;
        end
        S_DATA: begin
          if (bus_ack) begin
            exp7 <= in_data[BIT_DONE];
            st   <= abort_q ? S_RST1 : S_POLL;
          end else if (abort_q && !in_valid) begin
            st <= S_RST1;
          end
        end
        S_ERASE2: if (bus_ack) st <= abort_q ? S_RST1 : S_POLL;
        S_POLL, S_RECHK: if (bus_ack) begin
          if (abort_q) begin
            st <= S_RST1;
          end else if (ok7) begin
            if (last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              addr <= addr + AW'(1);
              left <= left - AW'(1);
              st   <= S_SETUP;
            end
          end else if (st == S_RECHK) begin
            st <= S_RST1;
          end else if (lim) begin
            st <= S_RECHK;
          end
        end
        S_RST1: if (bus_ack) st <= S_RST2;
        S_RST2: if (bus_ack) begin
          st          <= S_IDLE;
          fail_q      <= 1'b1;
          fail_addr_q <= addr;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hv_ready,
  input logic          start,
  input logic          in_ready,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ack,
  input logic          done,
  input logic          fail
);

  logic hv_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)        hv_seen <= 1'b0;
    else if (hv_ready) hv_seen <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !bus_req && !done && !fail && !in_ready);

  p_hv_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> hv_seen);

  p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) &&
                            $stable(bus_addr) && $stable(bus_wdata));

  p_take_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bus_req && bus_we);

  p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_fail_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hv_ready(hv_ready), .start(start),
  .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .done(done), .fail(fail)
);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, hv_ready = 1'b0, start = 1'b0, erase_mode = 1'b0, abort = 1'b0;
  logic [AW-1:0] start_addr = '0, byte_count = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, bus_req, bus_we, bus_ack, done, fail;
  logic [AW-1:0] bus_addr, fail_addr;
  logic [7:0] bus_wdata, bus_rdata;

  flash_prog_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .hv_ready(hv_ready), .start(start),
    .erase_mode(erase_mode), .abort(abort), .start_addr(start_addr),
    .byte_count(byte_count), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  int ntot = 0, nbad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model
  localparam logic [AW-1:0] FAIL_A = 8'h32, LATE_A = 8'h11;
  logic [7:0] mem [256];
  int mst = 0, pcnt = 0;
  logic [AW-1:0] baddr;
  logic [7:0] bdata;
  bit late = 0, erase_fail = 0;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_rdata <= 8'h00;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        case (mst)
          0: if (bus_wdata == 8'h10 || bus_wdata == 8'h50) mst = 1;
             else if (bus_wdata == 8'h30) mst = 3;
          1: begin
            baddr = bus_addr; bdata = bus_wdata;
            if (bus_wdata == 8'hFF) mst = 0;
            else begin
              mst  = (bus_addr == FAIL_A) ? 5 : 2;
              late = (bus_addr == LATE_A);
              pcnt = late ? 1 : 2;
            end
          end
          3: if (bus_wdata == 8'h30) begin mst = 4; pcnt = 4; end else mst = 0;
          default: if (bus_wdata == 8'hFF) mst = 0;
        endcase
      end else begin
        case (mst)
          2: if (pcnt == 0) begin
               mem[baddr] = mem[baddr] & bdata; mst = 0; bus_rdata <= mem[bus_addr];
             end else begin
               pcnt--; bus_rdata <= {~bdata[7], pcnt[0], late, 5'b0};
             end
          4: if (erase_fail) bus_rdata <= 8'h20;
             else if (pcnt == 0) begin
               for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
               mst = 0; bus_rdata <= 8'hFF;
             end else begin pcnt--; bus_rdata <= 8'h00; end
          5: if (pcnt == 0) bus_rdata <= {~bdata[7], 2'b01, 5'b0};
             else begin pcnt--; bus_rdata <= {~bdata[7], 7'b0}; end
          default: bus_rdata <= mem[bus_addr];
        endcase
      end
    end else bus_ack <= 1'b0;
  end

  // scoreboard
  typedef struct packed { logic [7:0] d; logic [AW-1:0] a; logic ca; } exp_t;
  exp_t q[$];
  int rd_cnt = 0, req_cnt = 0, hv_bad = 0;
  bit hv_watch = 0;

  task automatic push(input logic [7:0] d, input logic [AW-1:0] a, input logic ca);
    exp_t e;
    e.d = d; e.a = a; e.ca = ca;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req) req_cnt++;
      if (hv_watch && bus_req) hv_bad++;
      if (bus_req && bus_ack) begin
        if (!bus_we) rd_cnt++;
        else if (q.size() == 0) chk(0, "R3 unexpected write", int'(bus_wdata), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(bus_wdata == e.d, "R3 write data", int'(bus_wdata), int'(e.d));
          if (e.ca) chk(bus_addr == e.a, "R3 write addr", int'(bus_addr), int'(e.a));
        end
      end
    end
  end

  task automatic pulse_start(input logic [AW-1:0] a, input logic [AW-1:0] n, input logic er);
    @(negedge clk);
    start_addr = a; byte_count = n; erase_mode = er; start = 1'b1;
    @(negedge clk);
    start = 1'b0; erase_mode = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    while (1) begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk(0, "watchdog run end", 0, 1);
  endtask

  logic [7:0] pat1 [4] = '{8'h5A, 8'hA5, 8'h00, 8'hFF};
  logic [7:0] pat3 [3] = '{8'h12, 8'h34, 8'h9C};

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !in_ready, "R1 bus idle in reset", int'(bus_req), 0);
    chk(!done && !fail, "R1 flags in reset", int'({done, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !done && !fail, "R1 after reset", int'({bus_req, done, fail}), 0);

    // program 4 bytes, supply late, start while busy ignored
    for (int i = 0; i < 4; i++) begin push(8'h10, 0, 0); push(pat1[i], AW'(8'h10 + i), 1); end
    rd_cnt = 0;
    fork
      pulse_start(8'h10, 4, 0);
      for (int i = 0; i < 4; i++) send(pat1[i]);
      begin
        repeat (3) @(negedge clk);
        hv_watch = 1; repeat (20) @(negedge clk); hv_watch = 0; hv_ready = 1'b1;
      end
      begin
        repeat (30) @(negedge clk);
        start = 1'b1; erase_mode = 1'b1; start_addr = 8'h77;
        @(negedge clk); start = 1'b0; erase_mode = 1'b0;
      end
    join
    wait_end();
    chk(hv_bad == 0, "R2 access before supply ready", hv_bad, 0);
    chk(done && !fail, "R4 program done", int'({done, fail}), 2);
    chk(rd_cnt == 9, "R5 R6 poll read count", rd_cnt, 9);
    for (int i = 0; i < 4; i++)
      chk(mem[8'h10 + i] == pat1[i], "R4 programmed byte", int'(mem[8'h10 + i]), int'(pat1[i]));
    repeat (10) @(negedge clk);
    chk(done && !bus_req, "R10 done held", int'({done, bus_req}), 2);

    // program with a failing byte
    for (int i = 0; i < 3; i++) begin push(8'h10, 0, 0); push(pat3[i], AW'(8'h30 + i), 1); end
    push(8'hFF, 0, 0); push(8'hFF, 0, 0);
    rd_cnt = 0;
    fork
      pulse_start(8'h30, 3, 0);
      for (int i = 0; i < 3; i++) send(pat3[i]);
    join
    wait_end();
    chk(fail && !done, "R7 fail flag", int'({done, fail}), 1);
    chk(fail_addr == FAIL_A, "R7 fail address", int'(fail_addr), int'(FAIL_A));
    chk(rd_cnt == 10, "R7 poll reads incl. recheck", rd_cnt, 10);
    chk(mst == 0, "R7 device back in read mode", mst, 0);
    repeat (5) @(negedge clk);
    chk(fail, "R10 fail held", int'(fail), 1);

    // chip erase
    push(8'h30, 0, 0); push(8'h30, 0, 0);
    rd_cnt = 0;
    pulse_start(8'h05, 0, 1);
    chk(!fail, "R10 start clears fail", int'(fail), 0);
    wait_end();
    chk(done && !fail, "R8 erase done", int'({done, fail}), 2);
    chk(rd_cnt == 5, "R8 erase poll reads", rd_cnt, 5);
    chk(mem[8'h10] == 8'hFF && mem[8'h31] == 8'hFF, "R8 array erased",
        int'(mem[8'h10]), 8'hFF);

    // erase that never completes
    erase_fail = 1;
    push(8'h30, 0, 0); push(8'h30, 0, 0); push(8'hFF, 0, 0); push(8'hFF, 0, 0);
    rd_cnt = 0;
    pulse_start(8'h44, 0, 1);
    wait_end();
    erase_fail = 0;
    chk(fail && !done, "R8 erase fail flag", int'({done, fail}), 1);
    chk(fail_addr == 8'h44, "R8 erase fail address", int'(fail_addr), 8'h44);
    chk(rd_cnt == 2, "R6 single recheck on erase", rd_cnt, 2);

    // zero byte count
    req_cnt = 0;
    pulse_start(8'h50, 0, 0);
    chk(done && !fail, "R11 zero count done", int'({done, fail}), 2);
    repeat (5) @(negedge clk);
    chk(req_cnt == 0, "R11 no bus access", req_cnt, 0);

    // abort while waiting for supply
    hv_ready = 1'b0;
    push(8'hFF, 0, 0); push(8'hFF, 0, 0);
    rd_cnt = 0;
    pulse_start(8'h40, 2, 0);
    repeat (4) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_end();
    chk(fail && !done, "R9 abort flag", int'({done, fail}), 1);
    chk(fail_addr == 8'h40, "R9 abort address", int'(fail_addr), 8'h40);
    chk(rd_cnt == 0, "R9 no polling", rd_cnt, 0);
    hv_ready = 1'b1;

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 all expected writes seen", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    ntot++; nbad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule